// File: doc/BRIEF.md
# Ethernet Receive Frame Acceptance Filter

This block sits between a byte-wide receive stream and the buffer writer. Every frame passing through is checked in two ways: its CRC-32 frame check sequence, and the payload length it actually carries against the length/type field in bytes 13 and 14. On the way through it can drop the four trailing FCS bytes and can put up to three zero filler bytes in front of the frame. The filler lets the buffer writer align the payload behind the 14-byte header.

One cycle after the last byte is taken, the block raises a single-cycle verdict pulse. The pulse carries accept or discard and the number of bytes sent on the output for that frame, so the writer can keep or roll back what it has already stored. A saturating counter records frames rejected for a bad FCS. The configuration inputs are captured when a frame starts and stay fixed until it ends.

Both byte streams use valid/ready. A byte moves on a cycle where valid and ready are both high. A sender must hold valid and its data steady until the byte is taken. When `out_ready` is low, `in_ready` drops on every cycle that would have to produce an output byte, so nothing is lost and nothing is repeated. A byte that arrives outside a frame, with `in_sof` low, is accepted and thrown away.

Top module: `rx_frame_gate`

## Requirements
- R1: The CRC-32 runs reflected with polynomial 0x04C11DB7, starting from 0xFFFFFFFF. It covers every byte of the frame, the FCS bytes included, and the FCS is sent least significant byte first. A frame of at least 18 bytes whose final register value is not 0xDEBB20E3 is discarded when FCS-ignore is clear. A frame with a correct FCS and no other fault is accepted.
- R2: Each frame of at least 18 bytes that has a bad FCS, seen while FCS-ignore is clear, adds one to `fcs_err_cnt`. The counter is ERR_W bits wide (default 16) and stops at all ones. It returns to zero on a cycle where `err_clr` is high, and the clear takes priority over any increment.
- R3: When FCS-ignore is set, a bad FCS does not cause a discard and does not change `fcs_err_cnt`.
- R4: The length field is byte 13 as the high byte and byte 14 as the low byte. The measured length is the total byte count minus 18. When length checking is on and the field is below 0x0600, a frame whose measured length is less than the field is discarded. A measured length equal to or greater than the field is accepted. With length checking off, the field has no effect on the verdict.
- R5: A length/type value of 0x0600 or more is a type and never causes a length discard.
- R6: With FCS strip set, the last four bytes of the frame do not appear on the output and the reported count drops by four. The FCS is still checked.
- R7: A 2-bit offset N (0 to 3) puts N zero bytes, each with `out_valid` high, on the output before the first frame byte. They are included in the reported count.
- R8: `vd_done` is high for exactly one cycle, on the cycle after the end-of-frame byte is taken. On that cycle `vd_accept` holds the verdict and `vd_count` holds the number of output bytes the frame produced.
- R9: A frame shorter than 18 bytes is always discarded.
- R10: The configuration is captured when the start-of-frame byte is first presented. Changes made later in the frame have no effect on it.
- R11: While `out_ready` is held low, input is stalled. The output sequence is the same as it would be with no back-pressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_len_chk | input | 1 | Enable length-field check |
| cfg_fcs_strip | input | 1 | Drop the FCS from the output |
| cfg_fcs_ign | input | 1 | Do not reject or count bad FCS |
| cfg_offset | input | 2 | Number of leading zero filler bytes |
| err_clr | input | 1 | Synchronous clear of the FCS error counter |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with valid |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Buffer writer can take a byte |
| out_data | output | 8 | Output byte |
| vd_done | output | 1 | One-cycle verdict pulse |
| vd_accept | output | 1 | Frame accepted (valid with vd_done) |
| vd_count | output | CNT_W | Output bytes of the frame (valid with vd_done) |
| fcs_err_cnt | output | ERR_W | Saturating count of FCS-rejected frames |

## Verification
The frames tried are: a clean frame with a type field, one with a corrupted FCS, length fields just above and just at the measured length, and a type value right on the 0x0600 boundary next to 0x05FF. Together these separate an FCS fault from a length fault, and a length from a type. Frames of 17 and 18 bytes mark the runt limit. The strip, offset and FCS-ignore cases show that the output shaping is independent of the verdict logic. Changing the configuration in mid-frame, and toggling `out_ready` on every cycle, show that the captured configuration and the stall path leave the byte sequence, the count and the pulse timing unchanged.

// File: rtl/rxg_pkg.sv
package rxg_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_FRAME} rxg_state_e;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED      = 32'hFFFFFFFF;
  localparam logic [31:0] CRC_GOOD_RES  = 32'hDEBB20E3;
  localparam int          HDR_BYTES     = 14;
  localparam int          FCS_BYTES     = 4;
  localparam int          MIN_FRAME     = HDR_BYTES + FCS_BYTES;
  localparam logic [15:0] TYPE_FLOOR    = 16'h0600;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/rxg_crc.sv
module rxg_crc
  import rxg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        en,
  input  logic [7:0]  data,
  output logic [31:0] crc_nxt
);
  logic [31:0] crc_q;

  assign crc_nxt = crc_step(crc_q, data);

  always_ff @(posedge clk) begin
    if (!rst_n || start) crc_q <= CRC_SEED;
    else if (en)         crc_q <= crc_nxt;
  end
endmodule

// File: rtl/rxg_strip.sv
module rxg_strip #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         full,
  output logic [W-1:0] dout
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  line_q [DEPTH];
  logic [CW-1:0] fill_q;

  assign full = (fill_q == CW'(DEPTH));
  assign dout = line_q[DEPTH-1];

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      fill_q <= '0;
    end else if (push && !full) begin
      fill_q <= fill_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      line_q[0] <= din;
      for (int i = 1; i < DEPTH; i++) line_q[i] <= line_q[i-1];
    end
  end
endmodule

// File: rtl/rxg_judge.sv
module rxg_judge
  import rxg_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int ERR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_en,
  input  logic [CNT_W-1:0] byte_idx,
  input  logic [7:0]       data,
  input  logic             fin,
  input  logic [31:0]      crc_nxt,
  input  logic [CNT_W-1:0] out_total,
  input  logic             len_chk,
  input  logic             fcs_ign,
  input  logic             err_clr,
  output logic             done,
  output logic             accept,
  output logic [CNT_W-1:0] count,
  output logic [ERR_W-1:0] err_cnt
);
  logic [15:0]      fld_q;
  logic [CNT_W-1:0] len_q;
  logic [CNT_W-1:0] flen;
  logic [31:0]      meas;
  logic             runt, crc_ok, len_bad, verdict, bump;

  assign flen    = byte_idx + 1'b1;
  assign runt    = 32'(flen) < 32'(MIN_FRAME);
  assign meas    = 32'(flen) - 32'(MIN_FRAME);
  assign crc_ok  = (crc_nxt == CRC_GOOD_RES);
  assign len_bad = len_chk && (fld_q < TYPE_FLOOR) && (meas < 32'(fld_q));
  assign verdict = !runt && (crc_ok || fcs_ign) && !len_bad;
  assign bump    = fin && !runt && !crc_ok && !fcs_ign && (err_cnt != '1);

  always_ff @(posedge clk) begin
    if (byte_en && byte_idx == CNT_W'(HDR_BYTES - 2)) fld_q[15:8] <= data;
    if (byte_en && byte_idx == CNT_W'(HDR_BYTES - 1)) fld_q[7:0]  <= data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done   <= 1'b0;
      accept <= 1'b0;
      count  <= '0;
      len_q  <= '0;
    end else begin
      done <= fin;
      if (fin) begin
        accept <= verdict;
        count  <= out_total;
        len_q  <= flen;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || err_clr) err_cnt <= '0;
    else if (bump)         err_cnt <= err_cnt + 1'b1;
  end

  p_pulse_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_runt_reject_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && accept) |-> (32'(len_q) >= 32'(MIN_FRAME)));
  p_err_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !err_clr |=> (err_cnt == $past(err_cnt)) || (err_cnt == $past(err_cnt) + 1'b1));
  p_err_sat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt == '1 && !err_clr) |=> (err_cnt == '1));
  p_ign_no_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && fcs_ign && !err_clr) |=> (err_cnt == $past(err_cnt)));
endmodule

// File: rtl/rx_frame_gate.sv
module rx_frame_gate
  import rxg_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int ERR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_len_chk,
  input  logic             cfg_fcs_strip,
  input  logic             cfg_fcs_ign,
  input  logic [1:0]       cfg_offset,
  input  logic             err_clr,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_sof,
  input  logic             in_eof,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             vd_done,
  output logic             vd_accept,
  output logic [CNT_W-1:0] vd_count,
  output logic [ERR_W-1:0] fcs_err_cnt
);
  rxg_state_e       state_q;
  logic [1:0]       fill_q;
  logic             lchk_q, strip_q, ign_q;
  logic [CNT_W-1:0] bcnt_q, ocnt_q;
  logic             start, fire_in, fire_out, emit, fin;
  logic             dly_full;
  logic [7:0]       dly_out;
  logic [31:0]      crc_nxt;

  assign start    = (state_q == ST_IDLE) && in_valid && in_sof;
  assign emit     = !strip_q || dly_full;
  assign fire_in  = in_valid && in_ready;
  assign fire_out = out_valid && out_ready;
  assign fin      = (state_q == ST_FRAME) && fire_in && in_eof;

  always_comb begin
    in_ready  = 1'b0;
    out_valid = 1'b0;
    out_data  = 8'h00;
    case (state_q)
      ST_IDLE:  in_ready = !in_sof;
      ST_FILL:  out_valid = 1'b1;
      ST_FRAME: begin
        in_ready  = emit ? out_ready : 1'b1;
        out_valid = in_valid && emit;
        out_data  = strip_q ? dly_out : in_data;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      fill_q  <= '0;
      lchk_q  <= 1'b0;
      strip_q <= 1'b0;
      ign_q   <= 1'b0;
      bcnt_q  <= '0;
      ocnt_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          lchk_q  <= cfg_len_chk;
          strip_q <= cfg_fcs_strip;
          ign_q   <= cfg_fcs_ign;
          fill_q  <= cfg_offset;
          bcnt_q  <= '0;
          ocnt_q  <= '0;
          state_q <= (cfg_offset != 2'd0) ? ST_FILL : ST_FRAME;
        end
        ST_FILL: if (out_ready) begin
          fill_q <= fill_q - 1'b1;
          ocnt_q <= ocnt_q + 1'b1;
          if (fill_q == 2'd1) state_q <= ST_FRAME;
        end
        ST_FRAME: begin
          if (fire_in)  bcnt_q <= bcnt_q + 1'b1;
          if (fire_out) ocnt_q <= ocnt_q + 1'b1;
          if (fin)      state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  rxg_crc u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .en      ((state_q == ST_FRAME) && fire_in),
    .data    (in_data),
    .crc_nxt (crc_nxt)
  );

  rxg_strip #(.DEPTH(FCS_BYTES), .W(8)) u_strip (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (start),
    .push  ((state_q == ST_FRAME) && fire_in && strip_q),
    .din   (in_data),
    .full  (dly_full),
    .dout  (dly_out)
  );

  rxg_judge #(.CNT_W(CNT_W), .ERR_W(ERR_W)) u_judge (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_en   ((state_q == ST_FRAME) && fire_in),
    .byte_idx  (bcnt_q),
    .data      (in_data),
    .fin       (fin),
    .crc_nxt   (crc_nxt),
    .out_total (ocnt_q + CNT_W'(fire_out)),
    .len_chk   (lchk_q),
    .fcs_ign   (ign_q),
    .err_clr   (err_clr),
    .done      (vd_done),
    .accept    (vd_accept),
    .count     (vd_count),
    .err_cnt   (fcs_err_cnt)
  );

  p_verdict_after_eof_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> vd_done);
  p_fill_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FILL && out_ready) |=> (state_q != ST_IDLE));
  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> ($stable(strip_q) && $stable(lchk_q) && $stable(ign_q)));
  p_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FRAME && in_valid && emit && !out_ready) |=> ($stable(bcnt_q) && $stable(ocnt_q)));
endmodule

// File: tb/tb_rx_frame_gate.sv
module tb_rx_frame_gate;
  localparam int CNT_W = 16;
  localparam int ERR_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_len_chk = 0, cfg_fcs_strip = 0, cfg_fcs_ign = 0, err_clr = 0;
  logic [1:0] cfg_offset = 0;
  logic in_valid = 0, in_sof = 0, in_eof = 0, out_ready = 1;
  logic [7:0] in_data = 0;
  logic in_ready, out_valid, vd_done, vd_accept;
  logic [7:0] out_data;
  logic [CNT_W-1:0] vd_count;
  logic [ERR_W-1:0] fcs_err_cnt;

  rx_frame_gate #(.CNT_W(CNT_W), .ERR_W(ERR_W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_len_chk(cfg_len_chk), .cfg_fcs_strip(cfg_fcs_strip),
    .cfg_fcs_ign(cfg_fcs_ign), .cfg_offset(cfg_offset), .err_clr(err_clr),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_sof(in_sof),
    .in_eof(in_eof), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .vd_done(vd_done), .vd_accept(vd_accept), .vd_count(vd_count), .fcs_err_cnt(fcs_err_cnt)
  );

  always #10 clk = ~clk;

  int cyc = 0, checks = 0, errors = 0, exp_err = 0;
  int cap_n = 0, v_n = 0, v_cyc = 0, eof_cyc = 0;
  bit v_acc = 0, bp = 0;
  int v_cnt = 0;
  logic [7:0] fr [0:127];
  logic [7:0] cap [0:255];

  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) begin
    #2;
    out_ready = bp ? ~out_ready : 1'b1;
  end
  always @(negedge clk) begin
    if (out_valid && out_ready && cap_n < 256) begin
      cap[cap_n] = out_data;
      cap_n++;
    end
    if (vd_done) begin
      v_n++;
      v_acc = vd_accept;
      v_cnt = int'(vd_count);
      v_cyc = cyc;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  function automatic logic [31:0] tb_crc(input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {24'd0, fr[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic run_frame(string req, int n, logic [15:0] fld, bit bad, bit lc,
                           bit st, bit ig, int off, bit exp_acc, bit swap);
    logic [31:0] f;
    int m;
    bit same;
    for (int i = 0; i < n - 4; i++) fr[i] = 8'(i * 7 + 3);
    if (n > 13) begin
      fr[12] = fld[15:8];
      fr[13] = fld[7:0];
    end
    f = tb_crc(n - 4);
    for (int i = 0; i < 4; i++) fr[n - 4 + i] = f[8*i +: 8];
    if (bad) fr[n - 1] = fr[n - 1] ^ 8'h10;
    cfg_len_chk = lc; cfg_fcs_strip = st; cfg_fcs_ign = ig; cfg_offset = 2'(off);
    cap_n = 0; v_n = 0;
    for (int i = 0; i < n; i++) begin
      in_valid = 1; in_data = fr[i]; in_sof = (i == 0); in_eof = (i == n - 1);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      if (i == n - 1) eof_cyc = cyc;
      @(posedge clk); #1;
      if (i == 0 && swap) begin
        cfg_len_chk = !lc; cfg_fcs_strip = !st; cfg_fcs_ign = !ig; cfg_offset = 2'(off) ^ 2'd3;
      end
    end
    in_valid = 0; in_sof = 0; in_eof = 0;
    repeat (3) @(negedge clk);
    if (bad && !ig && n >= 18 && exp_err < 7) exp_err++;
    m = st ? n - 4 : n;
    same = 1;
    for (int k = 0; k < off + m; k++) begin
      if (cap[k] !== ((k < off) ? 8'h00 : fr[k - off])) same = 0;
    end
    check({req, " verdict pulses"}, v_n, 1);
    check({req, " R8 pulse timing"}, v_cyc, eof_cyc + 1);
    check({req, " accept"}, int'(v_acc), int'(exp_acc));
    check({req, " R8 count"}, v_cnt, off + m);
    check({req, " out bytes"}, cap_n, off + m);
    check({req, " data match"}, int'(same), 1);
    check({req, " R2 err counter"}, int'(fcs_err_cnt), exp_err);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check("R8 reset done", int'(vd_done), 0);
    check("R2 reset counter", int'(fcs_err_cnt), 0);
    check("R7 reset out_valid", int'(out_valid), 0);
    //           req   n   fld     bad lc st ig off acc swap
    run_frame("R1 good",        64, 16'h0800, 0, 0, 0, 0, 0, 1, 0);
    run_frame("R1 bad fcs",     64, 16'h0800, 1, 0, 0, 0, 0, 0, 0);
    run_frame("R3 ignore",      64, 16'h0800, 1, 0, 0, 1, 0, 1, 0);
    run_frame("R4 short len",   64, 16'd47,   0, 1, 0, 0, 0, 0, 0);
    run_frame("R4 exact len",   64, 16'd46,   0, 1, 0, 0, 0, 1, 0);
    run_frame("R4 check off",   64, 16'd47,   0, 0, 0, 0, 0, 1, 0);
    run_frame("R5 type 0x0600", 30, 16'h0600, 0, 1, 0, 0, 0, 1, 0);
    run_frame("R5 len 0x05FF",  30, 16'h05FF, 0, 1, 0, 0, 0, 0, 0);
    run_frame("R6 strip",       40, 16'h0800, 0, 0, 1, 0, 0, 1, 0);
    run_frame("R6 strip bad",   40, 16'h0800, 1, 0, 1, 0, 0, 0, 0);
    run_frame("R7 offset1",     24, 16'h0800, 0, 0, 0, 0, 1, 1, 0);
    run_frame("R7 offset2",     24, 16'h0800, 0, 0, 1, 0, 2, 1, 0);
    run_frame("R7 offset3",     24, 16'h0800, 0, 0, 0, 0, 3, 1, 0);
    run_frame("R9 runt17",      17, 16'h0800, 0, 0, 0, 0, 0, 0, 0);
    run_frame("R9 min18",       18, 16'h0800, 0, 0, 0, 0, 0, 1, 0);
    run_frame("R10 swap",       32, 16'd20,   1, 0, 0, 0, 2, 0, 1);
    bp = 1;
    run_frame("R11 stall",      36, 16'h0800, 0, 0, 1, 0, 3, 1, 0);
    run_frame("R11 stall raw",  36, 16'h0800, 0, 0, 0, 0, 1, 1, 0);
    bp = 0;
    @(posedge clk); #1 err_clr = 1;
    @(posedge clk); #1 err_clr = 0;
    @(negedge clk);
    exp_err = 0;
    check("R2 clear", int'(fcs_err_cnt), 0);
    for (int j = 0; j < 8; j++) run_frame("R2 saturate", 20, 16'h0800, 1, 0, 0, 0, 0, 0, 0);
    check("R2 saturated value", int'(fcs_err_cnt), 7);
    report();
  end
endmodule